// File: doc/BRIEF.md
# Pairwise Dot-Product Histogram Engine

This engine sweeps over pairs of three-component fixed-point vectors stored in an external word-addressed memory. For each pair it forms the full-precision dot product and presents it to an external bin-search unit. The search unit returns a bin index in the same cycle, and the engine increments the 64-bit counter of that bin. A one-cycle `start` pulse begins a run. The point counts and the pairing mode are latched at that pulse. A one-cycle `done` pulse ends the run, and the host then reads the counters through a lane/bin select port.

Two pairing modes exist. In auto-correlation mode every unordered pair drawn from one set is visited exactly once. In cross-correlation mode every point of the first set meets every point of the second set. The `LANES` parameter selects a single-lane build or a two-lane build. In the two-lane build each pass loads two consecutive outer points. Both are dotted against one shared stream of inner points, and each lane keeps its own histogram.

Top module: `pair_hist_engine`

## Requirements
- R1: After reset `busy` and `done` are low and every counter of every lane reads zero.
- R2: An accepted `start` clears all counters of all lanes, so a run's counts contain only that run's pairs.
- R3: With `auto_mode`=0 the engine visits every pair (i, j) with 0<=i<n1 and 0<=j<n2. Outer point i is read at address i. Inner point j is read at address n1+j.
- R4: With `auto_mode`=1 the engine visits exactly the pairs with 0<=i<=n1-2 and i<j<=n2-1, using the same addresses as R3.
- R5: Each memory word holds x in bits [17:0], y in bits [49:32] and z in bits [81:64], each a signed 18-bit value. The value on `srch_dot` is the exact 38-bit signed sum x_i*x_j + y_i*y_j + z_i*z_j.
- R6: For every visited pair, the counter of the bin returned on `srch_bin` rises by exactly one. No other counter changes.
- R7: `done` is a single-cycle pulse, raised exactly once per accepted start, in the cycle after the last counter update. `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored: the run in progress and its counts are unaffected.
- R9: When a run has no pairs (auto with n1<=1, or any mode with n1=0 or n2=0), `done` still arrives and all counters stay zero.
- R10: With LANES=2, lane k counts exactly the pairs whose outer index i satisfies i mod 2 = k. When the outer range is odd, the second lane is idle in the last pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse |
| auto_mode | input | 1 | 1 = pairs within one set, 0 = set 1 against set 2 |
| n1 | input | IDX_W | Number of outer points |
| n2 | input | IDX_W | Number of inner points |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, one-cycle pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | IDX_W+1 | Memory word address |
| mem_rdata | input | 128 | Word returned one cycle after the strobe |
| srch_vld | output | LANES | Per-lane dot product valid |
| srch_dot | output | LANES*DOT_W | Per-lane dot products sent to the bin search |
| srch_bin | input | LANES*BIN_W | Per-lane bin index from the bin search (same cycle) |
| rd_lane | input | LW | Lane select for readout |
| rd_bin | input | BIN_W | Bin select for readout |
| rd_count | output | CNT_W | Selected counter value |

## Verification
The bench builds two copies side by side: one with LANES=2 and one with LANES=1. Both use IDX_W=8, NBINS=32, CNT_W=64 and 18-bit coordinates, and they share one memory image. With both copies, the single-lane totals check the plain pairing order, and the two-lane counters check the split of pairs by outer-index parity, including the idle second lane on odd outer ranges. The small index width keeps runs short, so the bench can cover both modes, empty runs, extreme coordinates and a start pulse issued mid-run.

// File: rtl/phe_pkg.sv
package phe_pkg;
    localparam int WORD_W  = 128;
    localparam int FIELD_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NEXT,
        S_OLD,
        S_INNER,
        S_DRAIN
    } seq_st_e;
endpackage

// File: rtl/phe_seq.sv
module phe_seq
    import phe_pkg::*;
#(
    parameter int LANES = 2,
    parameter int IDX_W = 12,
    parameter int LW    = 1,
    localparam int AW   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             auto_mode,
    input  logic [IDX_W-1:0] n1,
    input  logic [IDX_W-1:0] n2,
    input  logic             pipe_busy,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    output logic             rt_v,
    output logic             rt_outer,
    output logic [LW-1:0]    rt_lane,
    output logic [LANES-1:0] rt_mask,
    output logic             clr,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        seq_st_e          st;
        logic [AW-1:0]    base;
        logic [AW-1:0]    j;
        logic [LW-1:0]    ld;
        logic [AW-1:0]    olim;
        logic [AW-1:0]    n1;
        logic [AW-1:0]    n2;
        logic             auto_m;
        logic             busy;
        logic             done;
        logic             rt_v;
        logic             rt_outer;
        logic [LW-1:0]    rt_lane;
        logic [LANES-1:0] rt_mask;
    } seq_s;

    seq_s q_q, q_d;

    always_comb begin
        q_d          = q_q;
        q_d.done     = 1'b0;
        q_d.rt_v     = 1'b0;
        q_d.rt_outer = 1'b0;
        q_d.rt_mask  = '0;
        mem_rd       = 1'b0;
        mem_addr     = '0;
        clr          = 1'b0;
        case (q_q.st)
            S_IDLE: begin
                if (start) begin
                    clr        = 1'b1;
                    q_d.busy   = 1'b1;
                    q_d.auto_m = auto_mode;
                    q_d.n1     = AW'(n1);
                    q_d.n2     = AW'(n2);
                    if (auto_mode)
                        q_d.olim = (n1 == '0) ? '0 : AW'(n1) - 1'b1;
                    else
                        q_d.olim = AW'(n1);
                    q_d.base = '0;
                    q_d.st   = S_NEXT;
                end
            end
            S_NEXT: begin
                if (q_q.base < q_q.olim) begin
                    q_d.ld = '0;
                    q_d.st = S_OLD;
                end else begin
                    q_d.st = S_DRAIN;
                end
            end
            S_OLD: begin
                mem_rd       = 1'b1;
                mem_addr     = q_q.base + AW'(q_q.ld);
                q_d.rt_v     = 1'b1;
                q_d.rt_outer = 1'b1;
                q_d.rt_lane  = q_q.ld;
                if (q_q.ld == LW'(LANES - 1)) begin
                    q_d.j  = q_q.auto_m ? q_q.base + 1'b1 : '0;
                    q_d.st = S_INNER;
                end else begin
                    q_d.ld = q_q.ld + 1'b1;
                end
            end
            S_INNER: begin
                if (q_q.j < q_q.n2) begin
                    mem_rd   = 1'b1;
                    mem_addr = q_q.j + q_q.n1;
                    q_d.rt_v = 1'b1;
                    for (int l = 0; l < LANES; l++) begin
                        q_d.rt_mask[l] = ((q_q.base + AW'(l)) < q_q.olim) &&
                                         (!q_q.auto_m || (q_q.j > q_q.base + AW'(l)));
                    end
                    q_d.j = q_q.j + 1'b1;
                    if (q_q.j + 1'b1 >= q_q.n2) begin
                        q_d.base = q_q.base + AW'(LANES);
                        q_d.st   = S_NEXT;
                    end
                end else begin
                    q_d.base = q_q.base + AW'(LANES);
                    q_d.st   = S_NEXT;
                end
            end
            S_DRAIN: begin
                if (!q_q.rt_v && !pipe_busy) begin
                    q_d.busy = 1'b0;
                    q_d.done = 1'b1;
                    q_d.st   = S_IDLE;
                end
            end
            default: q_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            q_q.st <= S_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    assign rt_v     = q_q.rt_v;
    assign rt_outer = q_q.rt_outer;
    assign rt_lane  = q_q.rt_lane;
    assign rt_mask  = q_q.rt_mask;
    assign busy     = q_q.busy;
    assign done     = q_q.done;
endmodule

// File: rtl/phe_lane.sv
module phe_lane
    import phe_pkg::*;
#(
    parameter int COORD_W = 18,
    parameter int LW      = 1,
    parameter int LANE_ID = 0,
    localparam int PW     = 2 * COORD_W,
    localparam int DOT_W  = PW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              rt_v,
    input  logic              rt_outer,
    input  logic [LW-1:0]     rt_lane,
    input  logic              rt_sel,
    output logic [DOT_W-1:0]  dot_o,
    output logic              dot_vld,
    output logic              mult_busy
);
    typedef struct packed {
        logic signed [COORD_W-1:0] ox;
        logic signed [COORD_W-1:0] oy;
        logic signed [COORD_W-1:0] oz;
        logic signed [PW-1:0]      px;
        logic signed [PW-1:0]      py;
        logic signed [PW-1:0]      pz;
        logic                      m_v;
        logic [DOT_W-1:0]          sum;
        logic                      s_v;
    } lane_s;

    lane_s q_q, q_d;
    logic signed [COORD_W-1:0] wx, wy, wz;

    assign wx = word[0*FIELD_W +: COORD_W];
    assign wy = word[1*FIELD_W +: COORD_W];
    assign wz = word[2*FIELD_W +: COORD_W];

    always_comb begin
        q_d = q_q;
        if (rt_v && rt_outer && (rt_lane == LW'(LANE_ID))) begin
            q_d.ox = wx;
            q_d.oy = wy;
            q_d.oz = wz;
        end
        q_d.m_v = rt_v && !rt_outer && rt_sel;
        q_d.px  = q_q.ox * wx;
        q_d.py  = q_q.oy * wy;
        q_d.pz  = q_q.oz * wz;
        q_d.s_v = q_q.m_v;
        q_d.sum = {{2{q_q.px[PW-1]}}, q_q.px} +
                  {{2{q_q.py[PW-1]}}, q_q.py} +
                  {{2{q_q.pz[PW-1]}}, q_q.pz};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign dot_o     = q_q.sum;
    assign dot_vld   = q_q.s_v;
    assign mult_busy = q_q.m_v;
endmodule

// File: rtl/phe_hist.sv
module phe_hist #(
    parameter int NBINS = 32,
    parameter int CNT_W = 64,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_v,
    input  logic [BIN_W-1:0] inc_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_cnt
);
    logic [CNT_W-1:0] cnt_q [NBINS];
    logic [CNT_W-1:0] cnt_d [NBINS];

    always_comb begin
        for (int b = 0; b < NBINS; b++) begin
            if (clr)
                cnt_d[b] = '0;
            else if (inc_v && (int'(inc_bin) == b))
                cnt_d[b] = cnt_q[b] + 1'b1;
            else
                cnt_d[b] = cnt_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBINS; b++) cnt_q[b] <= '0;
        end else begin
            for (int b = 0; b < NBINS; b++) cnt_q[b] <= cnt_d[b];
        end
    end

    assign rd_cnt = (int'(rd_bin) < NBINS) ? cnt_q[rd_bin] : '0;
endmodule

// File: rtl/pair_hist_engine.sv
module pair_hist_engine
    import phe_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int IDX_W   = 12,
    parameter int NBINS   = 32,
    parameter int CNT_W   = 64,
    parameter int COORD_W = 18,
    localparam int DOT_W  = 2 * COORD_W + 2,
    localparam int BIN_W  = $clog2(NBINS),
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int AW     = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   auto_mode,
    input  logic [IDX_W-1:0]       n1,
    input  logic [IDX_W-1:0]       n2,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_rd,
    output logic [AW-1:0]          mem_addr,
    input  logic [WORD_W-1:0]      mem_rdata,
    output logic [LANES-1:0]       srch_vld,
    output logic [LANES*DOT_W-1:0] srch_dot,
    input  logic [LANES*BIN_W-1:0] srch_bin,
    input  logic [LW-1:0]          rd_lane,
    input  logic [BIN_W-1:0]       rd_bin,
    output logic [CNT_W-1:0]       rd_count
);
    logic             rt_v, rt_outer, clr;
    logic [LW-1:0]    rt_lane;
    logic [LANES-1:0] rt_mask;
    logic [LANES-1:0] mult_busy;
    logic [CNT_W-1:0] lane_cnt [LANES];

    phe_seq #(.LANES(LANES), .IDX_W(IDX_W), .LW(LW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .auto_mode (auto_mode),
        .n1        (n1),
        .n2        (n2),
        .pipe_busy (|mult_busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .rt_v      (rt_v),
        .rt_outer  (rt_outer),
        .rt_lane   (rt_lane),
        .rt_mask   (rt_mask),
        .clr       (clr),
        .busy      (busy),
        .done      (done)
    );

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        phe_lane #(.COORD_W(COORD_W), .LW(LW), .LANE_ID(gl)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .word      (mem_rdata),
            .rt_v      (rt_v),
            .rt_outer  (rt_outer),
            .rt_lane   (rt_lane),
            .rt_sel    (rt_mask[gl]),
            .dot_o     (srch_dot[gl*DOT_W +: DOT_W]),
            .dot_vld   (srch_vld[gl]),
            .mult_busy (mult_busy[gl])
        );

        phe_hist #(.NBINS(NBINS), .CNT_W(CNT_W)) u_hist (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .inc_v   (srch_vld[gl]),
            .inc_bin (srch_bin[gl*BIN_W +: BIN_W]),
            .rd_bin  (rd_bin),
            .rd_cnt  (lane_cnt[gl])
        );
    end

    always_comb begin
        rd_count = '0;
        for (int l = 0; l < LANES; l++) begin
            if (int'(rd_lane) == l) rd_count = lane_cnt[l];
        end
    end
endmodule

// File: rtl/phe_chk.sv
module phe_chk #(
    parameter int LANES = 2,
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mem_rd,
    input logic [LANES-1:0] srch_vld
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    rd_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R6
    vld_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld != '0) |-> busy);
endmodule

bind pair_hist_engine phe_chk #(.LANES(LANES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .srch_vld (srch_vld)
);

// File: tb/test_pair_hist_engine.sv
`timescale 1ns/1ps
module test_pair_hist_engine;
    localparam int IDX_W = 8;
    localparam int NB    = 32;
    localparam int DW    = 38;
    localparam int BW    = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic auto_mode = 0;
    logic [IDX_W-1:0] n1 = 0, n2 = 0;
    logic [127:0] mem [512];

    logic a_busy, a_done, a_rd;
    logic [IDX_W:0] a_addr;
    logic [127:0] a_rdata;
    logic [1:0] a_vld;
    logic [2*DW-1:0] a_dot;
    logic [2*BW-1:0] a_bin;
    logic a_lane = 0;
    logic [BW-1:0] rbin = 0;
    logic [63:0] a_cnt;

    logic b_busy, b_done, b_rd;
    logic [IDX_W:0] b_addr;
    logic [127:0] b_rdata;
    logic [0:0] b_vld;
    logic [DW-1:0] b_dot;
    logic [BW-1:0] b_bin;
    logic [63:0] b_cnt;

    int errs = 0, checks = 0, a_dn = 0, b_dn = 0;
    longint ref_tot [NB];
    longint ref_ln [2][NB];

    always #2.5 clk = ~clk;

    function automatic logic [BW-1:0] bfun(input logic [DW-1:0] d);
        return d[37:33] ^ d[32:28];
    endfunction

    always_comb begin
        a_bin[0 +: BW]  = bfun(a_dot[0 +: DW]);
        a_bin[BW +: BW] = bfun(a_dot[DW +: DW]);
        b_bin           = bfun(b_dot);
    end

    always @(posedge clk) begin
        if (a_rd) a_rdata <= mem[a_addr];
        if (b_rd) b_rdata <= mem[b_addr];
        if (a_done) a_dn <= a_dn + 1;
        if (b_done) b_dn <= b_dn + 1;
    end

    pair_hist_engine #(.LANES(2), .IDX_W(IDX_W)) i_pair_hist_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
        .n1(n1), .n2(n2), .busy(a_busy), .done(a_done), .mem_rd(a_rd),
        .mem_addr(a_addr), .mem_rdata(a_rdata), .srch_vld(a_vld),
        .srch_dot(a_dot), .srch_bin(a_bin), .rd_lane(a_lane),
        .rd_bin(rbin), .rd_count(a_cnt));

    pair_hist_engine #(.LANES(1), .IDX_W(IDX_W)) i_pair_hist_engine_one (
        .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
        .n1(n1), .n2(n2), .busy(b_busy), .done(b_done), .mem_rd(b_rd),
        .mem_addr(b_addr), .mem_rdata(b_rdata), .srch_vld(b_vld),
        .srch_dot(b_dot), .srch_bin(b_bin), .rd_lane(1'b0),
        .rd_bin(rbin), .rd_count(b_cnt));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint crd(input logic [127:0] w, input int k);
        logic signed [17:0] v;
        v = w[32*k +: 18];
        return longint'(v);
    endfunction

    task automatic compute_ref(input bit am, input int c1, input int c2);
        int ilim;
        logic [DW-1:0] d;
        longint s;
        for (int b = 0; b < NB; b++) begin
            ref_tot[b] = 0; ref_ln[0][b] = 0; ref_ln[1][b] = 0;
        end
        ilim = am ? ((c1 > 0) ? c1 - 1 : 0) : c1;
        for (int i = 0; i < ilim; i++) begin
            for (int j = (am ? i + 1 : 0); j < c2; j++) begin
                s = 0;
                for (int k = 0; k < 3; k++) s += crd(mem[i], k) * crd(mem[c1 + j], k);
                d = s[DW-1:0];
                ref_tot[bfun(d)]++;
                ref_ln[i % 2][bfun(d)]++;
            end
        end
    endtask

    task automatic fill_rand(input int seed);
        int unsigned r = seed;
        for (int a = 0; a < 512; a++) begin
            mem[a] = '0;
            for (int k = 0; k < 3; k++) begin
                r = r * 1103515245 + 12345;
                mem[a][32*k +: 32] = {{14{r[25]}}, r[25:8]};
            end
        end
    endtask

    task automatic fill_extreme();
        for (int a = 0; a < 512; a++) begin
            mem[a] = '0;
            for (int k = 0; k < 3; k++)
                mem[a][32*k +: 32] = ((a + k) % 3 == 0) ? 32'hFFFE_0000 :
                                     ((a + k) % 3 == 1) ? 32'h0001_FFFF : 32'hFFFE_0001;
        end
    endtask

    task automatic launch(input bit am, input int c1, input int c2);
        @(negedge clk);
        auto_mode = am; n1 = IDX_W'(c1); n2 = IDX_W'(c2);
        a_dn = 0; b_dn = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic finish_and_check(input string req);
        int t = 0;
        while ((a_dn == 0 || b_dn == 0) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
        chk("R7", {req, " done pulses two-lane"}, a_dn, 1);
        chk("R7", {req, " done pulses one-lane"}, b_dn, 1);
        chk("R7", {req, " busy low two-lane"}, a_busy, 0);
        chk("R7", {req, " busy low one-lane"}, b_busy, 0);
        for (int b = 0; b < NB; b++) begin
            rbin = BW'(b);
            a_lane = 0; #1;
            chk(req, $sformatf("one-lane bin %0d", b), longint'(b_cnt), ref_tot[b]);
            chk("R10", $sformatf("%s lane0 bin %0d", req, b), longint'(a_cnt), ref_ln[0][b]);
            a_lane = 1; #1;
            chk("R10", $sformatf("%s lane1 bin %0d", req, b), longint'(a_cnt), ref_ln[1][b]);
            @(negedge clk);
        end
    endtask

    task automatic done_timing_test();
        int t = 0, seen = 0;
        fill_rand(77);
        compute_ref(0, 2, 3);
        launch(0, 2, 3);
        while (!b_done && t < 200) begin
            @(negedge clk); t++;
            rbin = 0; #1;
        end
        for (int b = 0; b < NB; b++) seen += int'(ref_tot[b]);
        chk("R7", "done arrives in one-lane run", b_done, 1);
        chk("R6", "pair count for 2x3 cross", seen, 6);
        repeat (40) @(negedge clk);
    endtask

    task automatic reset_test();
        #1;
        chk("R1", "busy after reset", a_busy | b_busy, 0);
        chk("R1", "done after reset", a_done | b_done, 0);
        for (int b = 0; b < NB; b += 7) begin
            rbin = BW'(b); a_lane = 1; #1;
            chk("R1", "two-lane counter after reset", longint'(a_cnt), 0);
            chk("R1", "one-lane counter after reset", longint'(b_cnt), 0);
        end
    endtask

    task automatic cross_test();
        fill_rand(11);
        compute_ref(0, 5, 7);
        launch(0, 5, 7);
        finish_and_check("R3");
    endtask

    task automatic auto_test();
        fill_rand(23);
        compute_ref(1, 8, 8);
        launch(1, 8, 8);
        finish_and_check("R4");
    endtask

    task automatic clear_test();
        fill_rand(5);
        compute_ref(1, 6, 6);
        launch(1, 6, 6);
        finish_and_check("R2");
    endtask

    task automatic extreme_test();
        fill_extreme();
        compute_ref(0, 4, 4);
        launch(0, 4, 4);
        finish_and_check("R5");
    endtask

    task automatic empty_test();
        compute_ref(1, 1, 1);
        launch(1, 1, 1);
        finish_and_check("R9");
        compute_ref(0, 0, 5);
        launch(0, 0, 5);
        finish_and_check("R9");
        compute_ref(0, 4, 0);
        launch(0, 4, 0);
        finish_and_check("R9");
    endtask

    task automatic busy_start_test();
        fill_rand(99);
        compute_ref(0, 6, 6);
        launch(0, 6, 6);
        repeat (10) @(negedge clk);
        auto_mode = 1; n1 = 3; n2 = 3;
        start = 1;
        @(negedge clk);
        start = 0;
        finish_and_check("R8");
    endtask

    initial begin
        #750000;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        reset_test();
        cross_test();
        auto_test();
        clear_test();
        extreme_test();
        empty_test();
        busy_start_test();
        done_timing_test();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule